// File: doc/BRIEF.md
# Ferroelectric Memory Identity Probe

This block runs a short, fixed command sequence on an SPI bus to find out what ferroelectric memory is attached. It runs once on its own after reset, and again each time `start` is pulsed. It begins with a status read and reports the device absent if the busy flag is set. Otherwise it reads the nine-byte identity string. It checks the manufacturer byte, then turns the density byte into a capacity in KiB and into the number of address bytes the memory expects.

When the identity string says a serial number is present, the block issues a second read and collects eight serial bytes. It stores them so that the byte received last sits in the least significant position. The outcome stays on the outputs until the next probe begins: a done flag, a pass flag, an error code, the capacity, the address byte count and the serial number. Other logic then uses these values to set up its own accesses to the memory.

Top module: `fram_probe_seq`

## Requirements
- R1: After reset is released, a probe starts without any `start` pulse. A one-cycle `start` pulse while idle starts a new probe. `done` is low from reset until the probe finishes.
- R2: The first transaction sends opcode 0x05 and receives one status byte. If bit 0 of that byte is 1, the probe ends with `ok`=0, `err_code`=1, and no further transaction is issued.
- R3: The second transaction sends opcode 0x9F and receives nine identity bytes, numbered 0 to 8. If byte 6 is not 0xC2, the probe ends with `ok`=0 and `err_code`=2.
- R4: If byte 7 lies outside 0x21..0x26, the probe ends with `ok`=0 and `err_code`=3. After any failed probe, `cap_kib`, `addr_bytes` and `serial_num` are all zero.
- R5: On a passing probe, `cap_kib` equals 16 shifted left by (byte 7 − 0x21), which covers 16 to 512 KiB.
- R6: On a passing probe, `addr_bytes` is 3 when the capacity exceeds 64 KiB and 2 otherwise.
- R7: If byte 8 is nonzero, a third transaction sends opcode 0xC3 and receives eight bytes. In `serial_num`, the first received byte sits in bits 63:56 and the last in bits 7:0.
- R8: If byte 8 is zero, no 0xC3 transaction is issued and `serial_num` is zero.
- R9: Chip select is high whenever no transaction is running, and goes high between transactions. `spi_sclk` is low whenever chip select is high.
- R10: A `start` pulse during a running probe is ignored. While `done` is high and no `start` arrives, all result outputs hold their values and the bus stays idle.
- R11: The bus uses SPI mode 0 with the most significant bit first. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge of SCLK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a new probe when idle |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the memory |
| spi_miso | input | 1 | SPI data from the memory |
| done | output | 1 | Probe finished; results valid |
| ok | output | 1 | Probe passed |
| err_code | output | 2 | 0 none, 1 busy/absent, 2 wrong manufacturer, 3 bad density |
| cap_kib | output | CAP_W (10) | Capacity in KiB |
| addr_bytes | output | 2 | Address bytes the memory uses (2 or 3) |
| serial_num | output | 8*SN_LEN (64) | Serial number, last received byte in bits 7:0 |

## Verification
The checker assumes that `start` is a single-cycle pulse and that the attached memory drives `spi_miso` only while chip select is low, changing it after falling SCLK edges. The bench's memory model updates MISO only on falling SCLK edges and on the fall of chip select. It raises `start` for exactly one cycle at a falling clock edge. The hold properties take for granted that nothing else disturbs the results after `done`. For that reason the bench checks stability only in stretches where it issues no `start`.

// File: rtl/fram_probe_pkg.sv
package fram_probe_pkg;

   localparam logic [7:0] OP_STATUS = 8'h05;
   localparam logic [7:0] OP_IDENT  = 8'h9F;
   localparam logic [7:0] OP_SERIAL = 8'hC3;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_ABSENT  = 2'd1,
      ERR_MFR     = 2'd2,
      ERR_DENSITY = 2'd3
   } probe_err_e;

   typedef enum logic [1:0] {
      PH_STAT,
      PH_IDENT,
      PH_SERIAL
   } probe_phase_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SEL,
      S_OPW,
      S_RXGO,
      S_RXW,
      S_DESEL,
      S_EVAL
   } probe_state_e;

endpackage

// File: rtl/fram_spi_byte.sv
module fram_spi_byte #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic [7:0] rx_byte,
   output logic       byte_done
);

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic       active_q;
   logic       sclk_q;
   logic [2:0] bit_q;
   logic [7:0] tx_q;
   logic [7:0] rx_q;
   logic       done_q;
   logic       tick;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("fram_spi_byte: CLK_DIV must be at least 1");
   end

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = active_q;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!active_q || div_q == DIV_W'(CLK_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = active_q && (div_q == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sclk_q   <= 1'b0;
         bit_q    <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!active_q) begin
            if (go) begin
               active_q <= 1'b1;
               tx_q     <= tx_byte;
               bit_q    <= '0;
               sclk_q   <= 1'b0;
            end
         end else if (tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[6:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_q  <= {tx_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign sclk      = sclk_q;
   assign mosi      = tx_q[7];
   assign rx_byte   = rx_q;
   assign byte_done = done_q;

endmodule

// File: rtl/fram_id_decode.sv
module fram_id_decode #(
   parameter logic [7:0] MFR_CODE = 8'hC2,
   parameter logic [7:0] DENS_MIN = 8'h21,
   parameter logic [7:0] DENS_MAX = 8'h26,
   parameter int         BASE_KIB = 16,
   parameter int         WIDE_KIB = 64,
   parameter int         CAP_W    = 10
) (
   input  logic [7:0]       mfr_byte,
   input  logic [7:0]       dens_byte,
   input  logic [7:0]       sn_flag_byte,
   output logic             mfr_ok,
   output logic             dens_ok,
   output logic [CAP_W-1:0] cap_kib,
   output logic [1:0]       addr_bytes,
   output logic             want_sn
);

   localparam int SPAN = int'(DENS_MAX) - int'(DENS_MIN);
   localparam int SH_W = (SPAN > 0) ? $clog2(SPAN + 1) : 1;

   if (DENS_MAX < DENS_MIN) begin : g_bad_range
      $error("fram_id_decode: density range is empty");
   end
   if ((BASE_KIB << SPAN) >= (1 << CAP_W)) begin : g_bad_capw
      $error("fram_id_decode: CAP_W too narrow for largest capacity");
   end

   logic [7:0]       dens_off;
   logic [SH_W-1:0]  shamt;

   always_comb begin
      mfr_ok     = (mfr_byte == MFR_CODE);
      dens_ok    = (dens_byte >= DENS_MIN) && (dens_byte <= DENS_MAX);
      dens_off   = dens_byte - DENS_MIN;
      shamt      = dens_off[SH_W-1:0];
      cap_kib    = dens_ok ? (CAP_W'(BASE_KIB) << shamt) : '0;
      addr_bytes = (cap_kib > CAP_W'(WIDE_KIB)) ? 2'd3 : 2'd2;
      want_sn    = (sn_flag_byte != 8'h00);
   end

endmodule

// File: rtl/fram_probe_seq.sv
module fram_probe_seq
   import fram_probe_pkg::*;
#(
   parameter int         CLK_DIV  = 2,
   parameter int         ID_LEN   = 9,
   parameter int         SN_LEN   = 8,
   parameter int         MFR_IDX  = 6,
   parameter int         DENS_IDX = 7,
   parameter int         SNF_IDX  = 8,
   parameter logic [7:0] MFR_CODE = 8'hC2,
   parameter int         CAP_W    = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                spi_sclk,
   output logic                spi_cs_n,
   output logic                spi_mosi,
   input  logic                spi_miso,
   output logic                done,
   output logic                ok,
   output logic [1:0]          err_code,
   output logic [CAP_W-1:0]    cap_kib,
   output logic [1:0]          addr_bytes,
   output logic [8*SN_LEN-1:0] serial_num
);

   localparam int SN_W   = 8 * SN_LEN;
   localparam int MAXLEN = (ID_LEN > SN_LEN) ? ID_LEN : SN_LEN;
   localparam int IDX_W  = $clog2(MAXLEN + 1);

   if (MFR_IDX >= ID_LEN || DENS_IDX >= ID_LEN || SNF_IDX >= ID_LEN) begin : g_bad_idx
      $error("fram_probe_seq: field index beyond identity length");
   end
   if (SN_LEN < 2) begin : g_bad_sn
      $error("fram_probe_seq: SN_LEN must be at least 2");
   end

   probe_state_e  state_q;
   probe_phase_e  phase_q;
   logic          kick_q;
   logic          cs_n_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]    id_mem [ID_LEN];
   logic [7:0]    stat_q;
   logic [SN_W-1:0] sn_sh_q;

   logic          done_q, ok_q;
   logic [1:0]    err_q;
   logic [CAP_W-1:0] cap_q;
   logic [1:0]    addr_q;
   logic [SN_W-1:0] serial_q;

   logic          go;
   logic [7:0]    tx_byte;
   logic [7:0]    rx_byte;
   logic          byte_done;
   logic [7:0]    opcode;
   logic [IDX_W-1:0] last_idx;
   logic          rx_take;

   logic             mfr_ok, dens_ok, want_sn;
   logic [CAP_W-1:0] dec_cap;
   logic [1:0]       dec_addr;

   fram_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .tx_byte   (tx_byte),
      .miso      (spi_miso),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi),
      .rx_byte   (rx_byte),
      .byte_done (byte_done)
   );

   fram_id_decode #(
      .MFR_CODE (MFR_CODE),
      .CAP_W    (CAP_W)
   ) u_dec (
      .mfr_byte     (id_mem[MFR_IDX]),
      .dens_byte    (id_mem[DENS_IDX]),
      .sn_flag_byte (id_mem[SNF_IDX]),
      .mfr_ok       (mfr_ok),
      .dens_ok      (dens_ok),
      .cap_kib      (dec_cap),
      .addr_bytes   (dec_addr),
      .want_sn      (want_sn)
   );

   always_comb begin
      unique case (phase_q)
         PH_STAT:   begin opcode = OP_STATUS; last_idx = '0; end
         PH_IDENT:  begin opcode = OP_IDENT;  last_idx = IDX_W'(ID_LEN - 1); end
         default:   begin opcode = OP_SERIAL; last_idx = IDX_W'(SN_LEN - 1); end
      endcase
      go      = (state_q == S_SEL) || (state_q == S_RXGO);
      tx_byte = (state_q == S_SEL) ? opcode : 8'h00;
      rx_take = (state_q == S_RXW) && byte_done;
   end

   genvar g;
   generate
      for (g = 0; g < ID_LEN; g++) begin : g_idcap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_mem[g] <= '0;
            end else if (rx_take && phase_q == PH_IDENT && idx_q == IDX_W'(g)) begin
               id_mem[g] <= rx_byte;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         sn_sh_q <= '0;
      end else if (rx_take) begin
         if (phase_q == PH_STAT) begin
            stat_q <= rx_byte;
         end else if (phase_q == PH_SERIAL) begin
            sn_sh_q <= {sn_sh_q[SN_W-9:0], rx_byte};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         phase_q  <= PH_STAT;
         kick_q   <= 1'b1;
         cs_n_q   <= 1'b1;
         idx_q    <= '0;
         done_q   <= 1'b0;
         ok_q     <= 1'b0;
         err_q    <= ERR_NONE;
         cap_q    <= '0;
         addr_q   <= '0;
         serial_q <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (kick_q || start) begin
                  kick_q   <= 1'b0;
                  done_q   <= 1'b0;
                  ok_q     <= 1'b0;
                  err_q    <= ERR_NONE;
                  cap_q    <= '0;
                  addr_q   <= '0;
                  serial_q <= '0;
                  phase_q  <= PH_STAT;
                  idx_q    <= '0;
                  cs_n_q   <= 1'b0;
                  state_q  <= S_SEL;
               end
            end
            S_SEL:  state_q <= S_OPW;
            S_OPW:  if (byte_done) state_q <= S_RXGO;
            S_RXGO: state_q <= S_RXW;
            S_RXW: begin
               if (byte_done) begin
                  if (idx_q == last_idx) begin
                     cs_n_q  <= 1'b1;
                     state_q <= S_DESEL;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= S_RXGO;
                  end
               end
            end
            S_DESEL: state_q <= S_EVAL;
            S_EVAL: begin
               idx_q <= '0;
               unique case (phase_q)
                  PH_STAT: begin
                     if (stat_q[0]) begin
                        done_q  <= 1'b1;
                        err_q   <= ERR_ABSENT;
                        state_q <= S_IDLE;
                     end else begin
                        phase_q <= PH_IDENT;
                        cs_n_q  <= 1'b0;
                        state_q <= S_SEL;
                     end
                  end
                  PH_IDENT: begin
                     if (!mfr_ok) begin
                        done_q  <= 1'b1;
                        err_q   <= ERR_MFR;
                        state_q <= S_IDLE;
                     end else if (!dens_ok) begin
                        done_q  <= 1'b1;
                        err_q   <= ERR_DENSITY;
                        state_q <= S_IDLE;
                     end else if (want_sn) begin
                        phase_q <= PH_SERIAL;
                        cs_n_q  <= 1'b0;
                        state_q <= S_SEL;
                     end else begin
                        cap_q   <= dec_cap;
                        addr_q  <= dec_addr;
                        done_q  <= 1'b1;
                        ok_q    <= 1'b1;
                        state_q <= S_IDLE;
                     end
                  end
                  default: begin
                     cap_q    <= dec_cap;
                     addr_q   <= dec_addr;
                     serial_q <= sn_sh_q;
                     done_q   <= 1'b1;
                     ok_q     <= 1'b1;
                     state_q  <= S_IDLE;
                  end
               endcase
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign spi_cs_n   = cs_n_q;
   assign done       = done_q;
   assign ok         = ok_q;
   assign err_code   = err_q;
   assign cap_kib    = cap_q;
   assign addr_bytes = addr_q;
   assign serial_num = serial_q;

endmodule

// File: rtl/fram_probe_chk.sv
module fram_probe_chk #(
   parameter int CAP_W = 10,
   parameter int SN_W  = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi,
   input logic             done,
   input logic             ok,
   input logic [1:0]       err_code,
   input logic [CAP_W-1:0] cap_kib,
   input logic [1:0]       addr_bytes,
   input logic [SN_W-1:0]  serial_num
);

   // R9
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R11
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   // R2
   err_excludes_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code != 2'd0) |-> !ok);

   // R4
   fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ok) |-> (cap_kib == '0 && addr_bytes == 2'd0 && serial_num == '0));

   // R6
   addr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok) |-> (addr_bytes == ((cap_kib > CAP_W'(64)) ? 2'd3 : 2'd2)));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(cap_kib) && $stable(serial_num)
                            && $stable(err_code) && spi_cs_n));

   // R1
   pass_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> done);

endmodule

bind fram_probe_seq fram_probe_chk #(.CAP_W(CAP_W), .SN_W(8*SN_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .spi_sclk   (spi_sclk),
   .spi_cs_n   (spi_cs_n),
   .spi_mosi   (spi_mosi),
   .done       (done),
   .ok         (ok),
   .err_code   (err_code),
   .cap_kib    (cap_kib),
   .addr_bytes (addr_bytes),
   .serial_num (serial_num)
);

// File: tb/sim_fram_probe_seq.sv
module sim_fram_probe_seq;

   localparam int CLK_PERIOD = 10;
   localparam int WAIT_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        done, ok;
   logic [1:0]  err_code;
   logic [9:0]  cap_kib;
   logic [1:0]  addr_bytes;
   logic [63:0] serial_num;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fram_probe_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .done(done), .ok(ok), .err_code(err_code), .cap_kib(cap_kib),
      .addr_bytes(addr_bytes), .serial_num(serial_num)
   );

   // memory model, SPI mode 0, MSB first
   logic [7:0] dev_status;
   logic [7:0] dev_id [9];
   logic [7:0] dev_sn [8];
   logic [7:0] op_log [16];
   int         op_cnt = 0;
   int         cs_falls = 0;
   int         byte_idx = 0;
   int         bit_idx = 0;
   logic [7:0] in_sh = 8'h00;
   logic [7:0] cur_op = 8'h00;

   function automatic logic [7:0] resp(input logic [7:0] op, input int k);
      if (op == 8'h05) return dev_status;
      if (op == 8'h9F) return (k < 9) ? dev_id[k] : 8'h00;
      if (op == 8'hC3) return (k < 8) ? dev_sn[k] : 8'h00;
      return 8'h00;
   endfunction

   always @(negedge spi_cs_n) begin
      cs_falls++;
      byte_idx = 0;
      bit_idx  = 0;
      spi_miso = 1'b0;
   end

   always @(posedge spi_sclk) begin
      if (!spi_cs_n) begin
         in_sh = {in_sh[6:0], spi_mosi};
         bit_idx++;
         if (bit_idx == 8) begin
            if (byte_idx == 0) begin
               cur_op = in_sh;
               if (op_cnt < 16) op_log[op_cnt] = in_sh;
               op_cnt++;
            end
            byte_idx++;
            bit_idx = 0;
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n && byte_idx >= 1) begin
         logic [7:0] b;
         b = resp(cur_op, byte_idx - 1);
         spi_miso = b[7 - bit_idx];
      end
   end

   task automatic chk(input bit cond, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_good_dev(input logic [7:0] dens, input logic [7:0] snf);
      dev_status = 8'h00;
      for (int i = 0; i < 9; i++) dev_id[i] = 8'h10 + 8'(i);
      dev_id[6] = 8'hC2;
      dev_id[7] = dens;
      dev_id[8] = snf;
      for (int i = 0; i < 8; i++) dev_sn[i] = 8'h11 * 8'(i + 1);
   endtask

   task automatic wait_done();
      int n;
      n = 0;
      while (!done && n < WAIT_LIMIT) begin
         @(negedge clk);
         n++;
      end
      if (!done) chk(1'b0, "watchdog", 64'(n), 64'(WAIT_LIMIT));
   endtask

   task automatic run_probe();
      op_cnt = 0;
      cs_falls = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
   endtask

   function automatic logic [63:0] exp_serial();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*i +: 8] = dev_sn[7-i];
      return v;
   endfunction

   task automatic t_auto_after_reset();
      set_good_dev(8'h22, 8'h01);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1 done in reset", 64'(done), 0);
      // R9 idle bus in reset
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R9 idle in reset", {62'b0, spi_cs_n, spi_sclk}, 2);
      rst_n = 1'b1;
      wait_done();
      chk(ok == 1'b1 && err_code == 2'd0, "R1 auto probe passes", {62'b0, err_code}, 0);
      // R11 opcodes decoded MSB first by the mode 0 model
      chk(op_cnt == 3 && op_log[0] == 8'h05 && op_log[1] == 8'h9F && op_log[2] == 8'hC3,
          "R11 R2 R3 R7 opcode order", {op_log[0], op_log[1], op_log[2]}, 64'h059FC3);
      chk(cs_falls == 3 && spi_cs_n == 1'b1, "R9 three selects", 64'(cs_falls), 3);
      chk(cap_kib == 10'd32, "R5 cap for 0x22", 64'(cap_kib), 32);
      chk(addr_bytes == 2'd2, "R6 addr for 32K", 64'(addr_bytes), 2);
      chk(serial_num == exp_serial(), "R7 reversed serial", serial_num, exp_serial());
      chk(serial_num[7:0] == dev_sn[7], "R7 last byte at bits 7:0", 64'(serial_num[7:0]), 64'(dev_sn[7]));
   endtask

   task automatic t_no_serial();
      set_good_dev(8'h26, 8'h00);
      run_probe();
      chk(ok && cap_kib == 10'd512, "R5 cap for 0x26", 64'(cap_kib), 512);
      chk(addr_bytes == 2'd3, "R6 addr for 512K", 64'(addr_bytes), 3);
      chk(op_cnt == 2, "R8 no serial command", 64'(op_cnt), 2);
      chk(serial_num == 64'd0, "R8 serial zero", serial_num, 0);
   endtask

   task automatic t_density_sweep();
      for (int d = 0; d < 6; d++) begin
         set_good_dev(8'h21 + 8'(d), 8'h00);
         run_probe();
         chk(ok && cap_kib == 10'(16 << d), "R5 density sweep", 64'(cap_kib), 64'(16 << d));
         chk(addr_bytes == ((d >= 3) ? 2'd3 : 2'd2), "R6 density sweep",
             64'(addr_bytes), (d >= 3) ? 3 : 2);
      end
   endtask

   task automatic t_absent();
      set_good_dev(8'h22, 8'h01);
      dev_status = 8'h03;
      run_probe();
      chk(!ok && err_code == 2'd1, "R2 busy status", 64'(err_code), 1);
      chk(op_cnt == 1, "R2 no identity read", 64'(op_cnt), 1);
   endtask

   task automatic t_bad_mfr();
      set_good_dev(8'h22, 8'h01);
      dev_id[6] = 8'hC1;
      run_probe();
      chk(!ok && err_code == 2'd2, "R3 wrong manufacturer", 64'(err_code), 2);
      chk(op_cnt == 2 && serial_num == 64'd0, "R3 stops after ident", 64'(op_cnt), 2);
   endtask

   task automatic t_bad_density();
      set_good_dev(8'h20, 8'h01);
      run_probe();
      chk(!ok && err_code == 2'd3, "R4 density 0x20", 64'(err_code), 3);
      chk(cap_kib == 0 && addr_bytes == 0 && serial_num == 0, "R4 zero results", 64'(cap_kib), 0);
      set_good_dev(8'h27, 8'h01);
      run_probe();
      chk(!ok && err_code == 2'd3, "R4 density 0x27", 64'(err_code), 3);
   endtask

   task automatic t_start_ignored();
      logic [63:0] held;
      set_good_dev(8'h24, 8'h05);
      op_cnt = 0;
      cs_falls = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      chk(done == 1'b0, "R10 done low while running", 64'(done), 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(op_cnt == 3 && cs_falls == 3, "R10 mid-run start ignored", 64'(cs_falls), 3);
      chk(ok && cap_kib == 10'd128 && addr_bytes == 2'd3, "R6 128K uses 3", 64'(addr_bytes), 3);
      held = serial_num;
      dev_sn[0] = 8'hEE;
      repeat (300) @(negedge clk);
      chk(done && cs_falls == 3 && serial_num == held, "R10 results held, bus idle",
          64'(cs_falls), 3);
   endtask

   initial begin
      set_good_dev(8'h22, 8'h01);
      t_auto_after_reset();
      t_no_serial();
      t_density_sweep();
      t_absent();
      t_bad_mfr();
      t_bad_density();
      t_start_ignored();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule